// File: doc/BRIEF.md
# Block-Tiled Surface Address Calculator

This block turns a surface description and a pixel coordinate into the register values a copy engine needs to walk a block-tiled three-dimensional surface. Given a 40-bit base address, a 12-bit tile mode, the surface width and height, an x/y/z position and the bytes per pixel, it works out the byte address of the first pixel. It also produces the row pitch measured in whole tile rows, a y-tile word giving the tile height and the rows left in the first tile, and a configuration word. That word carries the high address byte together with a y/z tile-size field.

Each coordinate is split into a tile index and an offset inside the tile. Horizontally the split is done on the byte position x × bytes per pixel. The tile indices are folded into one linear tile number. That number is scaled by the tile size and added to the intra-tile offset and the base address. A linear mode skips the tiling arithmetic and forwards the base address and pitch unchanged.

Work starts with a one-cycle start pulse and passes through a three-stage pipeline. A new request may be accepted on every cycle.

Top module: `tile_addr_calc`

## Requirements
- R1: While reset is held low at a clock edge, done_o, wide_tile_o and all output words are 0 after that edge.
- R2: A start_i pulse sampled at clock edge k gives done_o high for exactly the one cycle after edge k+2, with the results of that request. Requests started on consecutive cycles complete on consecutive cycles. Outputs change only when done_o rises.
- R3: The tile mode is decoded as follows. Bits 3:0 equal to 0xE give a horizontal shift Tp of 4 and wide_tile_o = 0. Any other value gives Tp = 6 and wide_tile_o = 1. Bits 7:4 plus 2 give the vertical shift Th, and bits 11:8 give the depth shift Td.
- R4: The total offset is the sum of two parts. The intra-tile part is (Tzo << (Tp+Th)) + (Tyo << Tp) + Txo. The tile part is (Tz·nTy·nTx + Ty·nTx + Tx) << (Tp+Th+Td). Here Tx and Txo are the high part and the low Tp bits of x·bpp, Ty and Tyo are the high part and the low Th bits of y, and Tz and Tzo are the high part and the low Td bits of z.
- R5: The 40-bit sum {base_hi_i, base_lo_i} + offset wraps modulo 2^40. Its bits 31:0 appear on addr_lo_o and its bits 39:32 appear in cfg_o bits 23:16, so a carry out of the low word reaches the high byte.
- R6: In tiled mode pitch_o = (nTx − 1) << (Tp+Th+Td), with nTx = ceil(width·bpp / 2^Tp), truncated to 32 bits.
- R7: In tiled mode ytile_o = (2^Th << 12) | (2^Th − Tyo).
- R8: In tiled mode cfg_o is the high address byte in bits 23:16, ORed with the tile-size field (2^Th >> 2) << Td. The factor nTy in R4 is ceil(height / 2^Th).
- R9: In linear mode (linear_i = 1 with start_i) addr_lo_o = base_lo_i, cfg_o = base_hi_i << 16 and pitch_o = pitch_i zero-extended. ytile_o and wide_tile_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| linear_i | input | 1 | 1 = linear surface, 0 = tiled |
| base_hi_i | input | 8 | Base address bits 39:32 |
| base_lo_i | input | 32 | Base address bits 31:0 |
| pitch_i | input | 19 | Pitch used in linear mode |
| tile_mode_i | input | 12 | Tile shape code (see R3) |
| width_i | input | 19 | Surface width in pixels |
| height_i | input | 13 | Surface height in rows |
| x_i | input | 19 | X position in pixels |
| y_i | input | 13 | Y position in rows |
| z_i | input | 12 | Z position in slices |
| cpp_i | input | 5 | Bytes per pixel |
| done_o | output | 1 | Result valid pulse |
| addr_lo_o | output | 32 | Start address bits 31:0 |
| cfg_o | output | 32 | High address byte in 23:16, ORed with tile-size field |
| pitch_o | output | 32 | Surface pitch |
| ytile_o | output | 32 | Y-tile height and remaining-rows word |
| wide_tile_o | output | 1 | 64-byte-wide tile flag |

## Verification
The checker follows the structural rules on every cycle. It checks the reset state, that done_o follows start_i by exactly three edges, and that results never move between completions. It also checks that a linear request leaves the y-tile word and the wide-tile flag untouched, that a tiled pitch always has its low six bits clear, and that a tiled y-tile word is never zero. The actual arithmetic needs the bench's scenarios with hand-computed expectations. These cover the three-level tile split for several mode codes, the carry from the low address word into the high byte, wrap at 2^40, and back-to-back requests.

// File: rtl/tac_pkg.sv
// Shared types for the tiled surface address calculator.
// Assumes no shift amount exceeds 63, which holds for a 12-bit tile mode.
package tac_pkg;
    typedef logic [5:0] shamt_t;

    // Decoded tile geometry: per-axis shift amounts and the wide-tile flag.
    typedef struct packed {
        shamt_t tp;
        shamt_t th;
        shamt_t td;
        logic   wide;
    } tile_shift_t;

    localparam int NUM_AXES = 3;
endpackage

// File: rtl/tac_mode_decode.sv
// Turns the 12-bit tile mode into x, y and z shift amounts.
// Purely combinational; assumes the mode is stable while it is sampled.
module tac_mode_decode
    import tac_pkg::*;
(
    input  logic [11:0]  mode_i,
    output tile_shift_t  shift_o
);
    localparam logic [3:0] NARROW_CODE = 4'hE;

    // Decode each nibble into its axis shift.
    always_comb begin
        shift_o.wide = (mode_i[3:0] != NARROW_CODE);
        shift_o.tp   = shift_o.wide ? 6'd6 : 6'd4;
        shift_o.th   = {2'b00, mode_i[7:4]} + 6'd2;
        shift_o.td   = {2'b00, mode_i[11:8]};
    end
endmodule

// File: rtl/tac_coord_split.sv
// Splits a coordinate into a tile index (high part) and an in-tile offset
// (low sh bits). Combinational; assumes sh is below W.
module tac_coord_split
    import tac_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [W-1:0] val_i,
    input  shamt_t       sh_i,
    output logic [W-1:0] idx_o,
    output logic [W-1:0] off_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] mask;

    // Mask of the low sh bits, then split.
    always_comb begin
        mask  = (ONE << sh_i) - ONE;
        idx_o = val_i >> sh_i;
        off_o = val_i & mask;
    end
endmodule

// File: rtl/tac_tile_count.sv
// Number of tiles needed to cover a length: ceil(len / 2^sh).
// Combinational; assumes len + 2^sh does not exceed W bits.
module tac_tile_count
    import tac_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [W-1:0] len_i,
    input  shamt_t       sh_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] ONE = W'(1);

    // Round up to a whole tile, then drop the in-tile bits.
    always_comb begin
        count_o = (len_i + ((ONE << sh_i) - ONE)) >> sh_i;
    end
endmodule

// File: rtl/tile_addr_calc.sv
// Three-stage calculator of start address, pitch, y-tile word and config
// word for a block-tiled or linear surface.
// Stage 1 decodes the mode and forms the byte products, stage 2 splits the
// coordinates and counts tiles, and stage 3 merges the offsets and
// registers the outputs.
// Assumes AW is between 33 and 48, so the high byte fits in cfg bits 31:16.
module tile_addr_calc
    import tac_pkg::*;
#(
    parameter int AW   = 40,
    parameter int PW   = 19,
    parameter int XW   = 19,
    parameter int YW   = 13,
    parameter int ZW   = 12,
    parameter int CPPW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            linear_i,
    input  logic [AW-33:0]  base_hi_i,
    input  logic [31:0]     base_lo_i,
    input  logic [PW-1:0]   pitch_i,
    input  logic [11:0]     tile_mode_i,
    input  logic [XW-1:0]   width_i,
    input  logic [YW-1:0]   height_i,
    input  logic [XW-1:0]   x_i,
    input  logic [YW-1:0]   y_i,
    input  logic [ZW-1:0]   z_i,
    input  logic [CPPW-1:0] cpp_i,
    output logic            done_o,
    output logic [31:0]     addr_lo_o,
    output logic [31:0]     cfg_o,
    output logic [31:0]     pitch_o,
    output logic [31:0]     ytile_o,
    output logic            wide_tile_o
);
    localparam int LW   = 32;
    localparam int HI_W = AW - LW;
    localparam logic [AW-1:0] ONE = AW'(1);

    // ---------------- stage 1: decode and byte products ----------------
    tile_shift_t  dec_shift;
    logic         s1_vld, s1_lin;
    logic [AW-1:0] s1_base;
    logic [PW-1:0] s1_pitch;
    tile_shift_t  s1_shift;
    logic [AW-1:0] s1_coord [NUM_AXES];
    logic [AW-1:0] s1_wbytes, s1_height;

    tac_mode_decode u_decode (
        .mode_i  (tile_mode_i),
        .shift_o (dec_shift)
    );

    // Capture the request with decoded shifts and byte-scaled x and width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld    <= 1'b0;
            s1_lin    <= 1'b0;
            s1_base   <= '0;
            s1_pitch  <= '0;
            s1_shift  <= '0;
            s1_wbytes <= '0;
            s1_height <= '0;
            for (int i = 0; i < NUM_AXES; i++) s1_coord[i] <= '0;
        end else begin
            s1_vld <= start_i;
            if (start_i) begin
                s1_lin      <= linear_i;
                s1_base     <= {base_hi_i, base_lo_i};
                s1_pitch    <= pitch_i;
                s1_shift    <= dec_shift;
                s1_coord[0] <= AW'(x_i) * AW'(cpp_i);
                s1_coord[1] <= AW'(y_i);
                s1_coord[2] <= AW'(z_i);
                s1_wbytes   <= AW'(width_i) * AW'(cpp_i);
                s1_height   <= AW'(height_i);
            end
        end
    end

    // ---------------- stage 2: split coordinates, count tiles ----------------
    shamt_t       axis_sh  [NUM_AXES];
    logic [AW-1:0] axis_idx [NUM_AXES];
    logic [AW-1:0] axis_off [NUM_AXES];
    logic [AW-1:0] ntx_c, nty_c, intra_c, th_pow;
    logic [LW-1:0] ytile_c, yz_c;
    shamt_t       ts_c;

    // Shift amount used by each axis.
    always_comb begin
        axis_sh[0] = s1_shift.tp;
        axis_sh[1] = s1_shift.th;
        axis_sh[2] = s1_shift.td;
    end

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        tac_coord_split #(.W(AW)) u_split (
            .val_i (s1_coord[g]),
            .sh_i  (axis_sh[g]),
            .idx_o (axis_idx[g]),
            .off_o (axis_off[g])
        );
    end

    tac_tile_count #(.W(AW)) u_cnt_x (
        .len_i   (s1_wbytes),
        .sh_i    (s1_shift.tp),
        .count_o (ntx_c)
    );

    tac_tile_count #(.W(AW)) u_cnt_y (
        .len_i   (s1_height),
        .sh_i    (s1_shift.th),
        .count_o (nty_c)
    );

    // In-tile offset, total shift, y-tile word and y/z tile-size field.
    always_comb begin
        th_pow  = ONE << s1_shift.th;
        intra_c = (axis_off[2] << (s1_shift.tp + s1_shift.th))
                + (axis_off[1] << s1_shift.tp)
                + axis_off[0];
        ts_c    = s1_shift.tp + s1_shift.th + s1_shift.td;
        ytile_c = LW'((th_pow << 12) | (th_pow - axis_off[1]));
        yz_c    = LW'((th_pow >> 2) << s1_shift.td);
    end

    logic         s2_vld, s2_lin, s2_wide;
    logic [AW-1:0] s2_base, s2_tx, s2_ty, s2_tz, s2_ntx, s2_nty, s2_intra;
    logic [PW-1:0] s2_pitch;
    logic [LW-1:0] s2_ytile, s2_yz;
    shamt_t       s2_ts;

    // Register the split results for the merge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld   <= 1'b0;
            s2_lin   <= 1'b0;
            s2_wide  <= 1'b0;
            s2_base  <= '0;
            s2_pitch <= '0;
            s2_tx    <= '0;
            s2_ty    <= '0;
            s2_tz    <= '0;
            s2_ntx   <= '0;
            s2_nty   <= '0;
            s2_intra <= '0;
            s2_ts    <= '0;
            s2_ytile <= '0;
            s2_yz    <= '0;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_lin   <= s1_lin;
                s2_wide  <= s1_shift.wide;
                s2_base  <= s1_base;
                s2_pitch <= s1_pitch;
                s2_tx    <= axis_idx[0];
                s2_ty    <= axis_idx[1];
                s2_tz    <= axis_idx[2];
                s2_ntx   <= ntx_c;
                s2_nty   <= nty_c;
                s2_intra <= intra_c;
                s2_ts    <= ts_c;
                s2_ytile <= ytile_c;
                s2_yz    <= yz_c;
            end
        end
    end

    // ---------------- stage 3: merge offsets and register outputs ----------------
    logic [AW-1:0] tile_num_c, total_c;
    logic [LW-1:0] pitch_tiled_c, cfg_tiled_c;

    // Linear tile number, full address and tiled pitch / config.
    always_comb begin
        tile_num_c    = s2_tz * s2_nty * s2_ntx + s2_ty * s2_ntx + s2_tx;
        total_c       = s2_base + (tile_num_c << s2_ts) + s2_intra;
        pitch_tiled_c = LW'((s2_ntx - ONE) << s2_ts);
        cfg_tiled_c   = LW'({total_c[AW-1:LW], 16'h0000}) | s2_yz;
    end

    // Output registers: update on completion only; linear keeps tiled words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            addr_lo_o   <= '0;
            cfg_o       <= '0;
            pitch_o     <= '0;
            ytile_o     <= '0;
            wide_tile_o <= 1'b0;
        end else begin
            done_o <= s2_vld;
            if (s2_vld) begin
                if (s2_lin) begin
                    addr_lo_o <= s2_base[LW-1:0];
                    cfg_o     <= LW'({s2_base[AW-1:LW], 16'h0000});
                    pitch_o   <= LW'(s2_pitch);
                end else begin
                    addr_lo_o   <= total_c[LW-1:0];
                    cfg_o       <= cfg_tiled_c;
                    pitch_o     <= pitch_tiled_c;
                    ytile_o     <= s2_ytile;
                    wide_tile_o <= s2_wide;
                end
            end
        end
    end

    logic unused_hi;
    assign unused_hi = ^HI_W;
endmodule

// File: rtl/tile_addr_calc_chk.sv
// Property checker for tile_addr_calc, attached with bind below.
// Tracks start and mode per cycle in its own shift registers.
module tile_addr_calc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        linear_i,
    input logic        done_o,
    input logic [31:0] addr_lo_o,
    input logic [31:0] pitch_o,
    input logic [31:0] ytile_o,
    input logic        wide_tile_o
);
    logic [2:0] st_q, lin_q;

    // History of start and linear flags for the three-stage latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            lin_q <= '0;
        end else begin
            st_q  <= {st_q[1:0], start_i};
            lin_q <= {lin_q[1:0], linear_i};
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!done_o && addr_lo_o == 0 && ytile_o == 0)); // R1
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done_o == st_q[2]); // R2
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> ($stable(addr_lo_o) && $stable(pitch_o))); // R2
    AST_LINEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (done_o && lin_q[2]) |-> ($stable(ytile_o) && $stable(wide_tile_o))); // R9
    AST_PITCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !lin_q[2]) |-> (pitch_o[5:0] == 6'd0)); // R6
    AST_YTILE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !lin_q[2]) |-> (ytile_o != 32'd0)); // R7
endmodule

bind tile_addr_calc tile_addr_calc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .linear_i    (linear_i),
    .done_o      (done_o),
    .addr_lo_o   (addr_lo_o),
    .pitch_o     (pitch_o),
    .ytile_o     (ytile_o),
    .wide_tile_o (wide_tile_o)
);

// File: tb/tile_addr_calc_tb.sv
module tile_addr_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        linear_i = 1'b0;
    logic [7:0]  base_hi_i = '0;
    logic [31:0] base_lo_i = '0;
    logic [18:0] pitch_i = '0;
    logic [11:0] tile_mode_i = '0;
    logic [18:0] width_i = '0;
    logic [12:0] height_i = '0;
    logic [18:0] x_i = '0;
    logic [12:0] y_i = '0;
    logic [11:0] z_i = '0;
    logic [4:0]  cpp_i = '0;
    logic        done_o, wide_tile_o;
    logic [31:0] addr_lo_o, cfg_o, pitch_o, ytile_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    tile_addr_calc u_dut (.*);

    typedef struct packed {
        logic [11:0] mode;
        logic [7:0]  hi;
        logic [31:0] lo;
        logic [18:0] w;
        logic [12:0] h;
        logic [18:0] x;
        logic [12:0] y;
        logic [11:0] z;
        logic [4:0]  cpp;
        logic [31:0] e_addr;
        logic [31:0] e_cfg;
        logic [31:0] e_pitch;
        logic [31:0] e_ytile;
        logic        e_wide;
    } vec_t;

    // Hand-computed tiled vectors.
    localparam vec_t VECS [3] = '{
        // narrow tiles, Tp=4 Th=2 Td=0
        '{12'h00E, 8'h00, 32'h0000_1000, 19'd64,  13'd8,  19'd5,  13'd6,  12'd0,  5'd4,
          32'h0000_1464, 32'h0000_0001, 32'h0000_03C0, 32'h0000_4002, 1'b0},
        // wide tiles, Tp=6 Th=4 Td=1, carry into high byte
        '{12'h121, 8'h12, 32'hFFFF_F000, 19'd100, 13'd20, 19'd70, 13'd35, 12'd3,  5'd2,
          32'h0000_84CC, 32'h0013_0008, 32'h0000_1800, 32'h0001_000D, 1'b1},
        // wide tiles, Tp=6 Th=3 Td=3
        '{12'h315, 8'h01, 32'h0002_0000, 19'd32,  13'd9,  19'd20, 13'd10, 12'd13, 5'd4,
          32'h0002_7A90, 32'h0001_0010, 32'h0000_1000, 32'h0000_8006, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic lin, input logic [18:0] pit);
        start_i     = 1'b1;
        linear_i    = lin;
        tile_mode_i = v.mode;
        base_hi_i   = v.hi;
        base_lo_i   = v.lo;
        width_i     = v.w;
        height_i    = v.h;
        x_i         = v.x;
        y_i         = v.y;
        z_i         = v.z;
        cpp_i       = v.cpp;
        pitch_i     = pit;
    endtask

    task automatic check_tiled(input string tag, input vec_t v);
        chk({tag, " R4 addr"},   addr_lo_o, v.e_addr);
        chk({tag, " R5/R8 cfg"}, cfg_o,     v.e_cfg);
        chk({tag, " R6 pitch"},  pitch_o,   v.e_pitch);
        chk({tag, " R7 ytile"},  ytile_o,   v.e_ytile);
        chk({tag, " R3 wide"},   32'(wide_tile_o), 32'(v.e_wide));
    endtask

    // Start one request and sample its result on the done cycle.
    task automatic run_one(input vec_t v, input logic lin, input logic [18:0] pit);
        drive(v, lin, pit);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R2 done not early", 32'(done_o), 32'd0);
        @(negedge clk);
        chk("R2 done on third edge", 32'(done_o), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        vec_t wrapv, linv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 addr", addr_lo_o, 32'd0);
        chk("R1 cfg",  cfg_o,     32'd0);
        chk("R1 ytile", ytile_o,  32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of tiled vectors (R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 3; i++) begin
            run_one(VECS[i], 1'b0, 19'd0);
            check_tiled($sformatf("vec%0d", i), VECS[i]);
            @(negedge clk);
            chk("R2 single pulse", 32'(done_o), 32'd0);
        end

        // R9: linear request after a wide tiled one keeps ytile and wide flag
        linv = VECS[0];
        linv.hi = 8'h34;
        linv.lo = 32'h1234_5678;
        run_one(linv, 1'b1, 19'h00400);
        chk("R9 linear addr",  addr_lo_o, 32'h1234_5678);
        chk("R9 linear cfg",   cfg_o,     32'h0034_0000);
        chk("R9 linear pitch", pitch_o,   32'h0000_0400);
        chk("R9 ytile held",   ytile_o,   32'h0000_8006);
        chk("R9 wide held",    32'(wide_tile_o), 32'd1);

        // R5: wrap of the 40-bit address
        wrapv = '{12'h00E, 8'hFF, 32'hFFFF_FFFF, 19'd16, 13'd4, 19'd1, 13'd0, 12'd0, 5'd1,
                  32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'h0000_4004, 1'b0};
        run_one(wrapv, 1'b0, 19'd0);
        check_tiled("wrap R5", wrapv);

        // R2: back-to-back requests complete on consecutive cycles
        @(negedge clk);
        drive(VECS[0], 1'b0, 19'd0);
        @(negedge clk);
        drive(VECS[1], 1'b0, 19'd0);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R2 b2b first done", 32'(done_o), 32'd1);
        check_tiled("b2b first", VECS[0]);
        @(negedge clk);
        chk("R2 b2b second done", 32'(done_o), 32'd1);
        check_tiled("b2b second", VECS[1]);
        @(negedge clk);
        chk("R2 b2b idle", 32'(done_o), 32'd0);
        chk("R2 outputs held", addr_lo_o, VECS[1].e_addr);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reassert addr", addr_lo_o, 32'd0);
        chk("R1 reassert wide", 32'(wide_tile_o), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule